// File: doc/BRIEF.md
# Trimmable One-Second Prescaler

This block turns a free-running 32.768 kHz tick enable into a one-second pulse and keeps a 0-to-59 seconds count beside it. Three times a minute, on the seconds numbered 0, 20 and 40, the length of that single second is moved away from its nominal 32768 ticks. The offset is a signed, even number of ticks held in a 7-bit trim code. This lets firmware correct a slow or fast crystal digitally, without touching the oscillator.

The trim code sits in a byte-wide register written through a simple write strobe. A write is taken only when bit 7 of the byte is 0, and bit 7 always reads back as 0. A stop input clears the register, the prescaler and the seconds count together, and holds all three at zero while it is high. The length of each second is fixed when that second begins, so software may rewrite the code at any time without disturbing the second already under way.

Top module: `rtc_trim_prescaler`

## Requirements
- R1: A second whose number is not 0, 20 or 40 lasts exactly NOMINAL_CYCLES ticks, and `sec_pulse` marks the end of every second.
- R2: A second whose number is 0, 20 or 40 lasts NOMINAL_CYCLES plus the signed offset given by the trim code that was in force when that second began.
- R3: With trim bit 6 = 0, the offset is +2 x (bits 5..0 - 1); code 0x07 gives a 172-tick second when NOMINAL_CYCLES = 160.
- R4: With trim bit 6 = 1, the offset is 2 x the 7-bit two's-complement value of the code; code 0x7E gives -4 ticks and code 0x42 gives -124 ticks.
- R5: Any code whose bits 5..1 are all zero (0x00, 0x01, 0x40, 0x41) gives an offset of 0.
- R6: A write with `wr_data[7]` = 0 loads bits 6..0 into the trim register; a write with `wr_data[7]` = 1 is ignored; `rd_data` is {0, trim[6:0]}.
- R7: While `stop` is high, the trim register, the prescaler and `sec_count` are all held at 0 and no pulse is produced; counting resumes from second 0 once it falls.
- R8: A second's length is latched when it begins. A write made during a second, including a trim second, does not change that second's length; the new code first acts at the next second numbered 0, 20 or 40.
- R9: `sec_pulse` is high for exactly one clock, in the cycle after the clock edge that took the last tick of a second.
- R10: `sec_count` advances in the same cycle that `sec_pulse` rises, and wraps from 59 to 0.
- R11: Only clocks with `tick_en` high are counted; idle clocks between ticks do not shorten a second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-clock enable, high once per 32.768 kHz period |
| stop | input | 1 | Synchronous stop: clears the trim and holds the counters at zero |
| wr_en | input | 1 | Write strobe for the trim register |
| wr_data | input | 8 | Write byte; bit 7 must be 0 for the write to be taken |
| rd_data | output | 8 | Trim register readback, bit 7 always 0 |
| sec_pulse | output | 1 | One-clock pulse at the end of every second |
| sec_count | output | SEC_W (6) | Current second, 0 to 59 |

## Verification
The assertions assume NOMINAL_CYCLES is large enough that the shortest trimmed second still lasts at least two ticks, so a pulse can never be followed at once by another. They also assume that `stop` and the write strobe are sampled on the same clock as `tick_en`. The stimulus uses a 160-tick nominal second, well above the 124-tick largest shortening, and changes every input on the falling clock edge. It mixes unbroken ticks with stretches where a pseudo-random pattern gates `tick_en`.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;

  localparam int TRIM_W  = 7;
  localparam int DELTA_W = 9;
  // largest lengthening a code can request, in ticks
  localparam int MAX_STRETCH = 124;

  // Signed tick offset for one trim second. The code doubled is the
  // 7-bit value with a zero appended; positive codes also lose one step.
  function automatic logic signed [DELTA_W-1:0] trim_delta(input logic [TRIM_W-1:0] code);
    if (code[5:1] == 5'd0) return '0;
    if (code[6]) return $signed({code[6], code, 1'b0});
    return $signed({1'b0, code, 1'b0}) - 9'sd2;
  endfunction

  function automatic logic is_trim_second(input int sec, input int step);
    return (sec % step) == 0;
  endfunction

  function automatic int second_length(input int nominal, input logic [TRIM_W-1:0] code,
                                       input logic trim_sec);
    return trim_sec ? nominal + int'(trim_delta(code)) : nominal;
  endfunction

endpackage

// File: rtl/rtc_trim_reg.sv
module rtc_trim_reg
  import rtc_trim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [TRIM_W-1:0] trim_code
);

  logic              wr_take;
  logic [TRIM_W-1:0] trim_q;

  assign wr_take = wr_en && !wr_data[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       trim_q <= '0;
    else if (stop)    trim_q <= '0;
    else if (wr_take) trim_q <= wr_data[TRIM_W-1:0];
  end

  assign trim_code = trim_q;

  // R6: a byte with its top bit set leaves the register untouched
  a_r6_reject_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[7] && !stop) |=> $stable(trim_q));

  // R6: a clean write lands the low seven bits
  a_r6_accept_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[7] && !stop) |=> (trim_q == $past(wr_data[TRIM_W-1:0])));

  // R7: stop wipes the code
  a_r7_stop_clears_trim: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (trim_q == '0));

endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter
  import rtc_trim_pkg::*;
#(
  parameter int SEC_LAST  = 59,
  parameter int TRIM_STEP = 20,
  parameter int SEC_W     = $clog2(SEC_LAST + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop,
  input  logic             advance,
  output logic [SEC_W-1:0] sec_q,
  output logic             next_is_trim
);

  logic [SEC_W-1:0] sec_next;

  assign sec_next     = (sec_q == SEC_W'(SEC_LAST)) ? '0 : sec_q + 1'b1;
  assign next_is_trim = is_trim_second(int'(sec_next), TRIM_STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sec_q <= '0;
    else if (stop)    sec_q <= '0;
    else if (advance) sec_q <= sec_next;
  end

  // R10: the count never leaves 0..SEC_LAST
  a_r10_sec_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    sec_q <= SEC_W'(SEC_LAST));

  // R10: last second rolls over to zero
  a_r10_sec_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !stop && sec_q == SEC_W'(SEC_LAST)) |=> (sec_q == '0));

  // R7: stop pins the seconds at zero
  a_r7_stop_holds_sec: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (sec_q == '0));

endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
  import rtc_trim_pkg::*;
#(
  parameter int NOMINAL_CYCLES = 32768,
  parameter int CNT_W          = $clog2(NOMINAL_CYCLES + MAX_STRETCH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop,
  input  logic              tick_en,
  input  logic              next_is_trim,
  input  logic [TRIM_W-1:0] trim_code,
  output logic              wrap,
  output logic              sec_pulse
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] next_len;
  logic             pulse_q;

  assign next_len = CNT_W'(second_length(NOMINAL_CYCLES, trim_code, next_is_trim));
  assign wrap     = tick_en && !stop && (cnt_q == len_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      len_q   <= CNT_W'(NOMINAL_CYCLES);
      pulse_q <= 1'b0;
    end else if (stop) begin
      cnt_q   <= '0;
      len_q   <= CNT_W'(NOMINAL_CYCLES);
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= wrap;
      if (wrap) begin
        cnt_q <= '0;
        len_q <= next_len;
      end else if (tick_en) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign sec_pulse = pulse_q;

  // R8: the length chosen at a second's start holds until its end
  a_r8_len_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap && !stop) |=> $stable(len_q));

  // R1: a plain second gets the nominal length
  a_r1_plain_length: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !next_is_trim) |=> (len_q == CNT_W'(NOMINAL_CYCLES)));

  // R2: the count stays below the latched length
  a_r2_cnt_below_len: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < len_q);

  // R9: the pulse never lasts two clocks
  a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |=> !sec_pulse);

  // R11: idle clocks leave the count alone
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !stop) |=> $stable(cnt_q));

  // R7: stop clears the prescaler and suppresses the pulse
  a_r7_stop_prescaler: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (cnt_q == '0 && !sec_pulse));

endmodule

// File: rtl/rtc_trim_prescaler.sv
module rtc_trim_prescaler
  import rtc_trim_pkg::*;
#(
  parameter int NOMINAL_CYCLES = 32768,
  parameter int SEC_LAST       = 59,
  parameter int TRIM_STEP      = 20,
  parameter int SEC_W          = $clog2(SEC_LAST + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             stop,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  output logic             sec_pulse,
  output logic [SEC_W-1:0] sec_count
);

  localparam int CNT_W = $clog2(NOMINAL_CYCLES + MAX_STRETCH + 1);

  logic [TRIM_W-1:0] trim_code;
  logic              wrap;
  logic              next_is_trim;

  rtc_trim_reg u_trim (
    .clk       (clk),
    .rst_n     (rst_n),
    .stop      (stop),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .trim_code (trim_code)
  );

  rtc_sec_counter #(
    .SEC_LAST  (SEC_LAST),
    .TRIM_STEP (TRIM_STEP),
    .SEC_W     (SEC_W)
  ) u_sec (
    .clk          (clk),
    .rst_n        (rst_n),
    .stop         (stop),
    .advance      (wrap),
    .sec_q        (sec_count),
    .next_is_trim (next_is_trim)
  );

  rtc_prescaler #(
    .NOMINAL_CYCLES (NOMINAL_CYCLES),
    .CNT_W          (CNT_W)
  ) u_pre (
    .clk          (clk),
    .rst_n        (rst_n),
    .stop         (stop),
    .tick_en      (tick_en),
    .next_is_trim (next_is_trim),
    .trim_code    (trim_code),
    .wrap         (wrap),
    .sec_pulse    (sec_pulse)
  );

  assign rd_data = {1'b0, trim_code};

  // R10: seconds move exactly when the pulse appears
  a_r10_sec_moves_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop && !$stable(sec_count)) |-> sec_pulse);

  // R6: readback top bit is always clear
  a_r6_rd_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7] == 1'b0);

endmodule

// File: tb/sim_rtc_trim_prescaler.sv
module sim_rtc_trim_prescaler;

  localparam int NOM  = 160;
  localparam int LAST = 59;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       stop = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       sec_pulse;
  logic [5:0] sec_count;

  always #10 clk = ~clk;

  rtc_trim_prescaler #(.NOMINAL_CYCLES(NOM)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .stop(stop),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .sec_pulse(sec_pulse), .sec_count(sec_count)
  );

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // independent offset rule
  function automatic int ref_delta(input int code);
    if (((code >> 1) & 31) == 0) return 0;
    if (code >= 64) return -2 * (128 - code);
    return 2 * ((code & 63) - 1);
  endfunction

  // behavioural reference, advanced on each rising edge
  int m_cnt = 0, m_len = NOM, m_sec = 0, m_trim = 0;
  bit m_pulse = 0;
  always @(posedge clk) begin
    if (!rst_n || stop) begin
      m_cnt = 0; m_len = NOM; m_sec = 0; m_trim = 0; m_pulse = 0;
    end else begin
      m_pulse = 0;
      if (tick_en) begin
        m_cnt++;
        if (m_cnt == m_len) begin
          m_cnt = 0;
          m_sec = (m_sec + 1) % (LAST + 1);
          m_len = (m_sec % 20 == 0) ? NOM + ref_delta(m_trim) : NOM;
          m_pulse = 1;
        end
      end
      if (wr_en && wr_data[7] == 1'b0) m_trim = wr_data & 8'h7F;
    end
  end

  // tick counting between pulses, plus a cycle counter
  int acc = 0, last_len = 0, cycle_no = 0;
  always @(posedge clk) begin
    cycle_no++;
    if (!rst_n || stop) acc = 0;
    else if (sec_pulse) begin
      last_len = acc;
      acc = tick_en ? 1 : 0;
    end else if (tick_en) acc++;
  end

  // per-cycle comparison with the reference
  bit cmp_on = 0;
  always @(negedge clk) begin
    if (rst_n && cmp_on && !done) begin
      chk("R6 rd_data", rd_data, m_trim);
      chk("R9 sec_pulse", sec_pulse, m_pulse);
      chk("R10 sec_count", sec_count, m_sec);
    end
  end

  // tick pattern generator
  bit gaps = 0;
  logic [15:0] lfsr = 16'hACE1;
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tick_en = rst_n && (!gaps || lfsr[0] || lfsr[1]);
  end

  task automatic wr(input logic [7:0] b);
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0; wr_data = 8'h00;
  endtask

  // returns two clocks after the pulse that opens second t; last_len then
  // holds the tick count of second t-1
  task automatic run_to_sec(input int t);
    do @(negedge clk); while (!(sec_pulse && sec_count == t));
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    chk("R6 reset rd_data", rd_data, 0);
    chk("R10 reset sec_count", sec_count, 0);
    chk("R9 reset sec_pulse", sec_pulse, 0);
    rst_n = 1'b1;
    cmp_on = 1;

    run_to_sec(1);
    chk("R1 second 0 untrimmed", last_len, NOM);
    wr(8'h07);
    chk("R6 write accepted", rd_data, 8'h07);
    run_to_sec(2);
    chk("R1 second 1 nominal", last_len, NOM);
    run_to_sec(21);
    chk("R3 code 0x07 lengthens", last_len, NOM + 12);
    run_to_sec(22);
    chk("R2 second 21 nominal", last_len, NOM);
    wr(8'h85);
    chk("R6 top-bit write ignored", rd_data, 8'h07);

    wr(8'h7E);
    run_to_sec(41);
    chk("R4 code 0x7E shortens", last_len, NOM - 4);
    wr(8'h42);
    run_to_sec(1);
    chk("R4 code 0x42 shortens most", last_len, NOM - 124);

    gaps = 1;
    c0 = cycle_no;
    run_to_sec(2);
    chk("R11 gapped second counts ticks", last_len, NOM);
    chk("R11 gapped second spans more clocks", int'((cycle_no - c0) > NOM), 1);

    wr(8'h01);
    run_to_sec(21);
    chk("R5 code 0x01 neutral", last_len, NOM);
    wr(8'h41);
    run_to_sec(41);
    chk("R5 code 0x41 neutral", last_len, NOM);
    wr(8'h40);
    run_to_sec(1);
    chk("R5 code 0x40 neutral", last_len, NOM);
    wr(8'h00);
    run_to_sec(21);
    chk("R5 code 0x00 neutral", last_len, NOM);

    wr(8'h07);
    run_to_sec(40);
    repeat (50) @(negedge clk);
    wr(8'h42);
    run_to_sec(41);
    chk("R8 mid-second write keeps length", last_len, NOM + 12);
    run_to_sec(59);
    do @(negedge clk); while (!sec_pulse);
    chk("R10 wrap 59 to 0", sec_count, 0);
    run_to_sec(1);
    chk("R8 new code at next trim second", last_len, NOM - 124);

    repeat (40) @(negedge clk);
    stop = 1'b1;
    repeat (20) begin
      @(negedge clk);
      chk("R7 stop no pulse", sec_pulse, 0);
    end
    chk("R7 stop clears trim", rd_data, 0);
    chk("R7 stop holds seconds", sec_count, 0);
    stop = 1'b0;
    gaps = 0;
    run_to_sec(1);
    chk("R7 restart from second 0", last_len, NOM);

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule